// File: doc/BRIEF.md
# Packed Multiply-Sum Accumulate Unit

This unit takes three 128-bit vectors, A, B and C, and treats each as four 32-bit lanes. Within a lane it multiplies the narrow elements of A and B pairwise. These are four bytes or two halfwords, depending on the mode. It adds every product to the lane's 32-bit word from C and returns one 32-bit word per lane. A six-bit mode code chooses three things: the element size, how each operand is extended, and whether an out-of-range sum wraps or is clamped.

Operands are accepted through a valid/ready handshake. The unit's control is a two-state machine. In `ST_EMPTY` it accepts an operand set. The transition `ACCEPT` (in_valid with in_ready) registers all four lane results and moves to `ST_FULL`. In `ST_FULL` the result is held with out_valid high. The transition `DRAIN` (out_ready while full) returns to `ST_EMPTY`. The unit produces one result for each accepted operand set.

A sticky flag reports that some lane of some accepted operation was clamped. Only reset clears it. Elements use big-endian numbering: lane 0 is bits 127:96 of every vector.

Top module: `msum_unit`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and sat_sticky is 0.
- R2: An operand set is accepted on a clock edge where in_valid and in_ready are both 1. out_valid is 1 from the next cycle. The result stays stable and in_ready stays 0 until a cycle with out_ready high. On that edge out_valid drops and in_ready returns to 1. Exactly one result is produced per accepted set.
- R3: Lane i (i = 0..3) uses bits [127-32i : 96-32i] of opa, opb and opc and writes the same bit range of result.
- R4: Mode 36 (unsigned byte, wrap): the lane result is C plus the products of the four zero-extended byte pairs, truncated to 32 bits.
- R5: Mode 37 (mixed byte, wrap): the lane result is C plus the four byte products, truncated to 32 bits. A bytes are sign-extended and B bytes are zero-extended.
- R6: Mode 38 (unsigned halfword, wrap): the lane result is C plus the products of the two zero-extended halfword pairs, truncated to 32 bits.
- R7: Mode 40 (signed halfword, wrap): the lane result is signed C plus the two signed halfword products, truncated to 32 bits.
- R8: Mode 41 (signed halfword, clamp): the same sum as R7 is formed without loss. A sum above 0x7FFFFFFF returns 0x7FFFFFFF. A sum below -2^31 returns 0x80000000. Either case counts as a clamp.
- R9: Mode 39 (unsigned halfword, clamp): the same sum as R6 is formed without loss. A sum above 0xFFFFFFFF returns 0xFFFFFFFF and counts as a clamp.
- R10: sat_sticky becomes 1 on the accepting edge of an operation in which any lane clamps. It stays 1 until reset. Wrapping modes never set it.
- R11: Any other mode code returns opc unchanged in every lane and never sets sat_sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can accept an operand set |
| mode | input | 6 | Operation code (36..41) |
| opa | input | 128 | Multiplicand vector A |
| opb | input | 128 | Multiplier vector B |
| opc | input | 128 | Accumulator vector C |
| out_valid | output | 1 | Result held and valid |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 128 | Four 32-bit lane results |
| sat_sticky | output | 1 | Some accepted operation clamped a lane |

## Verification
The assertions check the handshake on every cycle: output held stable while stalled, no acceptance while full, and a result after every acceptance. They also check that the sticky flag never falls, and that wrapping or unknown modes never raise it. The arithmetic of each mode cannot be shown by a property. That includes sign and zero extension, lane order, and the clamp limits at both ends of the signed range and at the top of the unsigned range. The bench shows these by sweeping every mode code through corner vectors and pseudo-random operands, and comparing each lane against sums it forms in 64-bit arithmetic.

// File: rtl/msum_pkg.sv
package msum_pkg;
    localparam logic [5:0] MODE_UBYTE_WRAP = 6'd36;
    localparam logic [5:0] MODE_MBYTE_WRAP = 6'd37;
    localparam logic [5:0] MODE_UHALF_WRAP = 6'd38;
    localparam logic [5:0] MODE_UHALF_CLMP = 6'd39;
    localparam logic [5:0] MODE_SHALF_WRAP = 6'd40;
    localparam logic [5:0] MODE_SHALF_CLMP = 6'd41;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } msum_state_e;
endpackage

// File: rtl/msum_lane.sv
module msum_lane
    import msum_pkg::*;
#(
    parameter int LANE_W = 32,
    parameter int BYTE_W = 8,
    parameter int HALF_W = 16,
    parameter int ACC_W  = 64
) (
    input  logic [5:0]        mode,
    input  logic [LANE_W-1:0] a_w,
    input  logic [LANE_W-1:0] b_w,
    input  logic [LANE_W-1:0] c_w,
    output logic [LANE_W-1:0] res,
    output logic              clamped
);
    localparam int NBYTE  = LANE_W / BYTE_W;
    localparam int NHALF  = LANE_W / HALF_W;
    localparam int EXT_W  = HALF_W + 2;
    localparam int PROD_W = 2 * EXT_W;

    logic                    byte_sel, a_sgn, b_sgn, c_sgn, known;
    logic signed [EXT_W-1:0] ea, eb;
    logic signed [PROD_W-1:0] prod;
    logic [ACC_W-1:0]        acc;

    always_comb begin
        byte_sel = (mode == MODE_UBYTE_WRAP) || (mode == MODE_MBYTE_WRAP);
        a_sgn    = (mode == MODE_MBYTE_WRAP) || (mode == MODE_SHALF_WRAP)
                || (mode == MODE_SHALF_CLMP);
        b_sgn    = (mode == MODE_SHALF_WRAP) || (mode == MODE_SHALF_CLMP);
        c_sgn    = b_sgn;
        known    = (mode >= MODE_UBYTE_WRAP) && (mode <= MODE_SHALF_CLMP);
        acc      = {{(ACC_W-LANE_W){c_sgn & c_w[LANE_W-1]}}, c_w};
        ea       = '0;
        eb       = '0;
        prod     = '0;
        if (byte_sel) begin
            for (int j = 0; j < NBYTE; j++) begin
                ea   = {{(EXT_W-BYTE_W){a_sgn & a_w[j*BYTE_W+BYTE_W-1]}}, a_w[j*BYTE_W +: BYTE_W]};
                eb   = {{(EXT_W-BYTE_W){b_sgn & b_w[j*BYTE_W+BYTE_W-1]}}, b_w[j*BYTE_W +: BYTE_W]};
                prod = ea * eb;
                acc  = acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
            end
        end else begin
            for (int j = 0; j < NHALF; j++) begin
                ea   = {{(EXT_W-HALF_W){a_sgn & a_w[j*HALF_W+HALF_W-1]}}, a_w[j*HALF_W +: HALF_W]};
                eb   = {{(EXT_W-HALF_W){b_sgn & b_w[j*HALF_W+HALF_W-1]}}, b_w[j*HALF_W +: HALF_W]};
                prod = ea * eb;
                acc  = acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
            end
        end

        res     = acc[LANE_W-1:0];
        clamped = 1'b0;
        if (!known) begin
            res = c_w;
        end else if (mode == MODE_SHALF_CLMP) begin
            if (acc[ACC_W-1:LANE_W-1] != '0 && acc[ACC_W-1:LANE_W-1] != '1) begin
                clamped = 1'b1;
                res     = acc[ACC_W-1] ? {1'b1, {(LANE_W-1){1'b0}}}
                                       : {1'b0, {(LANE_W-1){1'b1}}};
            end
        end else if (mode == MODE_UHALF_CLMP) begin
            if (acc[ACC_W-1:LANE_W] != '0) begin
                clamped = 1'b1;
                res     = '1;
            end
        end
    end
endmodule

// File: rtl/msum_ctrl.sv
module msum_ctrl
    import msum_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load
);
    msum_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)  state_d = ST_FULL;   // ACCEPT
            ST_FULL:  if (out_ready) state_d = ST_EMPTY;  // DRAIN
            default:                 state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: in_ready  = 1'b1;
            ST_FULL:  out_valid = 1'b1;
            default:  in_ready  = 1'b0;
        endcase
        load = in_ready & in_valid;
    end
endmodule

// File: rtl/msum_unit.sv
module msum_unit
    import msum_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [5:0]              mode,
    input  logic [LANES*LANE_W-1:0] opa,
    input  logic [LANES*LANE_W-1:0] opb,
    input  logic [LANES*LANE_W-1:0] opc,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*LANE_W-1:0] result,
    output logic                    sat_sticky
);
    localparam int VEC_W = LANES * LANE_W;

    logic                    load;
    logic [VEC_W-1:0]        lane_res;
    logic [LANES-1:0]        lane_clamp;

    msum_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        msum_lane #(.LANE_W(LANE_W)) lane_i (
            .mode    (mode),
            .a_w     (opa[VEC_W-1-i*LANE_W -: LANE_W]),
            .b_w     (opb[VEC_W-1-i*LANE_W -: LANE_W]),
            .c_w     (opc[VEC_W-1-i*LANE_W -: LANE_W]),
            .res     (lane_res[VEC_W-1-i*LANE_W -: LANE_W]),
            .clamped (lane_clamp[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            sat_sticky <= 1'b0;
        end else if (load) begin
            result     <= lane_res;
            sat_sticky <= sat_sticky | (|lane_clamp);
        end
    end
endmodule

// File: rtl/msum_chk.sv
module msum_chk #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [5:0]       mode,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] result,
    input logic             sat_sticky
);
    logic clamp_mode;
    assign clamp_mode = (mode == 6'd39) || (mode == 6'd41);

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(result)); // R2
    AST_NO_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R2
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R2
    AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid && in_ready); // R2
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sat_sticky |=> sat_sticky); // R10
    AST_WRAP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !clamp_mode && !sat_sticky |=> !sat_sticky); // R11
    AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) && !sat_sticky |=> !sat_sticky); // R10
endmodule

bind msum_unit msum_chk #(.VEC_W(LANES*LANE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .mode       (mode),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .result     (result),
    .sat_sticky (sat_sticky)
);

// File: tb/msum_unit_tb.sv
module msum_unit_tb_top;
    localparam real CYC = 4.0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         out_ready = 1'b0;
    logic [5:0]   mode = 6'd0;
    logic [127:0] opa = '0, opb = '0, opc = '0;
    logic         in_ready, out_valid, sat_sticky;
    logic [127:0] result;

    int  checks = 0;
    int  errors = 0;
    bit  exp_sticky = 1'b0;
    bit  done = 1'b0;

    always #(CYC/2) clk = ~clk;

    msum_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .mode(mode), .opa(opa), .opb(opb), .opc(opc),
        .out_valid(out_valid), .out_ready(out_ready),
        .result(result), .sat_sticky(sat_sticky)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [5:0] m);
        case (m)
            6'd36: return "R4";
            6'd37: return "R5";
            6'd38: return "R6";
            6'd39: return "R9";
            6'd40: return "R7";
            6'd41: return "R8";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [31:0] ref_lane(input logic [5:0] m, input logic [31:0] a,
                                             input logic [31:0] b, input logic [31:0] c,
                                             output bit clip);
        longint s;
        clip = 1'b0;
        case (m)
            6'd36: begin
                s = longint'(c);
                for (int j = 0; j < 4; j++) s += longint'(a[j*8 +: 8]) * longint'(b[j*8 +: 8]);
            end
            6'd37: begin
                s = longint'(c);
                for (int j = 0; j < 4; j++) s += longint'($signed(a[j*8 +: 8])) * longint'(b[j*8 +: 8]);
            end
            6'd38, 6'd39: begin
                s = longint'(c);
                for (int j = 0; j < 2; j++) s += longint'(a[j*16 +: 16]) * longint'(b[j*16 +: 16]);
                if (m == 6'd39 && s > 64'sh0FFFFFFFF) begin clip = 1'b1; s = 64'sh0FFFFFFFF; end
            end
            6'd40, 6'd41: begin
                s = longint'($signed(c));
                for (int j = 0; j < 2; j++)
                    s += longint'($signed(a[j*16 +: 16])) * longint'($signed(b[j*16 +: 16]));
                if (m == 6'd41 && s > 64'sh07FFFFFFF) begin clip = 1'b1; s = 64'sh07FFFFFFF; end
                if (m == 6'd41 && s < -64'sh080000000) begin clip = 1'b1; s = -64'sh080000000; end
            end
            default: s = longint'(c);
        endcase
        return s[31:0];
    endfunction

    task automatic run_op(input logic [5:0] m, input logic [127:0] a,
                          input logic [127:0] b, input logic [127:0] c);
        logic [127:0] exp;
        logic [127:0] held;
        bit clip;
        @(negedge clk);
        mode = m; opa = a; opb = b; opc = c; in_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            exp[127-32*i -: 32] = ref_lane(m, a[127-32*i -: 32], b[127-32*i -: 32], c[127-32*i -: 32], clip);
            exp_sticky |= clip;
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 out_valid after accept", {127'b0, out_valid}, 128'd1);
        check("R2 in_ready low while full", {127'b0, in_ready}, 128'd0);
        check(req_of(m), result, exp);
        check("R10 sticky", {127'b0, sat_sticky}, {127'b0, exp_sticky});
        held = result;
        @(negedge clk);
        check("R2 held while stalled", result, held);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        check("R2 drained", {126'b0, out_valid, in_ready}, 128'd1);
    endtask

    initial begin
        #(CYC * 200000);
        errors++;
        $display("FAIL watchdog expired");
        if (!done) $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [5:0] order [10] = '{6'd34, 6'd35, 6'd42, 6'd63, 6'd36, 6'd37, 6'd38, 6'd40, 6'd39, 6'd41};
        logic [127:0] ca [4] = '{{4{32'hFFFFFFFF}}, {8{16'h8000}}, {8{16'h8000}}, {4{32'h01020304}}};
        logic [127:0] cb [4] = '{{4{32'hFFFFFFFF}}, {8{16'h8000}}, {8{16'h7FFF}}, {4{32'hFF80017F}}};
        logic [127:0] cc [4] = '{{4{32'hFFFFFFFF}}, {4{32'h7FFFFFFF}}, {4{32'h80000000}}, {32'd0, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000}};
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", {125'b0, out_valid, in_ready, sat_sticky}, 128'd2);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {125'b0, out_valid, in_ready, sat_sticky}, 128'd2);
        // R3 lane order: only lane 0 of A non-zero
        @(negedge clk);
        mode = 6'd36; opa = {32'h01010101, 96'h0}; opb = {4{32'h01010101}};
        opc = {32'd0, 32'd1, 32'd2, 32'd3}; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 lane order", result, {32'd4, 32'd1, 32'd2, 32'd3});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        for (int k = 0; k < 10; k++) begin
            for (int v = 0; v < 4; v++) run_op(order[k], ca[v], cb[v], cc[v]);
            for (int r = 0; r < 30; r++)
                run_op(order[k], {$urandom, $urandom, $urandom, $urandom},
                       {$urandom, $urandom, $urandom, $urandom},
                       {$urandom, $urandom, $urandom, $urandom});
        end
        // R10 sticky stays after later wrapping op
        run_op(6'd36, '0, '0, '0);
        check("R10 sticky kept", {127'b0, sat_sticky}, 128'd1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule